// File: doc/BRIEF.md
# Memory-Reference Instruction Executor

This block carries out the execute steps of the seven memory-reference instructions of a small 16-bit accumulator machine: logical AND into the accumulator, add into the accumulator, load, store, unconditional branch, branch-and-save-return-address, and increment-and-skip-if-zero. It owns the accumulator, the carry/extend bit, the data register, the program counter and the address register. It drives a synchronous word memory: the address is always the address register, read data must match that address in the same cycle, and a write takes effect at the clock edge where the write strobe is high.

Fetch, decode and the indirect step are handled elsewhere. Those stages hand over their results through a load port that writes the address register (effective address), program counter, accumulator and extend bit. An external step counter then presents the execute steps as one-hot strobes (step 4, 5, 6) together with a one-hot decoded opcode. The block raises a sequence-clear output during the final step of each instruction so that the step counter restarts.

Top module: `mem_ref_exec`

## Requirements
- R1: While reset is low, and on the first cycle after release, every register output reads zero and `memWe` and `seqClr` are low.
- R2: `opDec` is one-hot with bit k selecting opcode k (0 AND, 1 ADD, 2 LDA, 3 STA, 4 BUN, 5 BSA, 6 ISZ). For AND, ADD and LDA, step 4 copies the memory word at the address register into the data register without `seqClr`; step 5 sets the accumulator to accumulator AND data, accumulator plus data (modulo 2^16), or data, and raises `seqClr`.
- R3: ADD writes the carry out of bit 15 into the extend bit; AND and LDA leave the extend bit unchanged.
- R4: STA, in step 4, drives `memWe` high with the accumulator on `memWdata` at the address register, and raises `seqClr`; the accumulator is unchanged.
- R5: BUN, in step 4, copies the address register into the program counter and raises `seqClr`.
- R6: BSA, in step 4, writes the 12-bit program counter zero-extended to 16 bits (bits 15:12 zero) at the address register and increments the address register (modulo 2^12); in step 5 it copies the address register into the program counter and raises `seqClr`.
- R7: ISZ loads the data register from memory in step 4, increments it in step 5, and in step 6 writes it back at the address register, increments the program counter when the incremented value is zero, and raises `seqClr`.
- R8: `memWe` is high in exactly one cycle per store (STA step 4, BSA step 4, ISZ step 6) and never otherwise.
- R9: With no step strobe active, or with a step strobe but no opcode bit, no register changes and `memWe` and `seqClr` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| t4 | input | 1 | Execute step 4 strobe |
| t5 | input | 1 | Execute step 5 strobe |
| t6 | input | 1 | Execute step 6 strobe |
| opDec | input | 7 | One-hot decoded opcode, bit k = opcode k |
| memRdata | input | 16 | Memory word at `memAddr`, same cycle |
| ldEn | input | 1 | Load address, PC, accumulator and extend bit from the earlier stages |
| ldAr | input | 12 | Effective address to load |
| ldPc | input | 12 | Program counter value to load |
| ldAc | input | 16 | Accumulator value to load |
| ldE | input | 1 | Extend bit value to load |
| memAddr | output | 12 | Memory address (the address register) |
| memWdata | output | 16 | Memory write data |
| memWe | output | 1 | Memory write strobe |
| seqClr | output | 1 | Clear the step counter; last step of the instruction |
| acOut | output | 16 | Accumulator |
| eOut | output | 1 | Extend bit |
| drOut | output | 16 | Data register |
| pcOut | output | 12 | Program counter |
| arOut | output | 12 | Address register |

## Verification
The hardest case is the ISZ skip, which needs a memory word of all ones to pass through a read, an increment to zero and a write-back across three steps before the program counter moves; the stimulus table seeds that word in the bench memory and also includes a non-wrapping ISZ for contrast. The BSA case at the top address is the other awkward corner, since the address register wraps to zero and the branch target follows it; a table row places the effective address there. Idle behaviour is reached by directed cycles that raise a step strobe with no opcode and an opcode with no step strobe, then read every register at the ports.

// File: rtl/mem_ref_exec_pkg.sv
package mem_ref_exec_pkg;

  localparam int OP_COUNT = 7;

  typedef enum logic [1:0] {
    WR_AC = 2'd0,
    WR_PC = 2'd1,
    WR_DR = 2'd2
  } wrSrc_e;

  typedef struct packed {
    logic   drFromMem;
    logic   drInc;
    logic   acAnd;
    logic   acAdd;
    logic   acLoadDr;
    logic   arInc;
    logic   pcFromAr;
    logic   pcSkipIfZero;
    logic   memWe;
    wrSrc_e wrSrc;
    logic   seqClr;
  } ctlStrobes_t;

endpackage

// File: rtl/mem_ref_exec_ctrl.sv
module mem_ref_exec_ctrl
  import mem_ref_exec_pkg::*;
(
  input  logic                t4,
  input  logic                t5,
  input  logic                t6,
  input  logic [OP_COUNT-1:0] opDec,
  output ctlStrobes_t         ctl
);

  localparam int OP_AND = 0;
  localparam int OP_ADD = 1;
  localparam int OP_LDA = 2;
  localparam int OP_STA = 3;
  localparam int OP_BUN = 4;
  localparam int OP_BSA = 5;
  localparam int OP_ISZ = 6;

  logic readsOperand;
  assign readsOperand = opDec[OP_AND] | opDec[OP_ADD] | opDec[OP_LDA] | opDec[OP_ISZ];

  always_comb begin
    ctl.drFromMem    = 1'b0;
    ctl.drInc        = 1'b0;
    ctl.acAnd        = 1'b0;
    ctl.acAdd        = 1'b0;
    ctl.acLoadDr     = 1'b0;
    ctl.arInc        = 1'b0;
    ctl.pcFromAr     = 1'b0;
    ctl.pcSkipIfZero = 1'b0;
    ctl.memWe        = 1'b0;
    ctl.wrSrc        = WR_AC;
    ctl.seqClr       = 1'b0;

    if (t4) begin
      if (readsOperand) ctl.drFromMem = 1'b1;
      if (opDec[OP_STA]) begin
        ctl.memWe  = 1'b1;
        ctl.wrSrc  = WR_AC;
        ctl.seqClr = 1'b1;
      end
      if (opDec[OP_BUN]) begin
        ctl.pcFromAr = 1'b1;
        ctl.seqClr   = 1'b1;
      end
      if (opDec[OP_BSA]) begin
        ctl.memWe = 1'b1;
        ctl.wrSrc = WR_PC;
        ctl.arInc = 1'b1;
      end
    end

    if (t5) begin
      if (opDec[OP_AND]) begin
        ctl.acAnd  = 1'b1;
        ctl.seqClr = 1'b1;
      end
      if (opDec[OP_ADD]) begin
        ctl.acAdd  = 1'b1;
        ctl.seqClr = 1'b1;
      end
      if (opDec[OP_LDA]) begin
        ctl.acLoadDr = 1'b1;
        ctl.seqClr   = 1'b1;
      end
      if (opDec[OP_BSA]) begin
        ctl.pcFromAr = 1'b1;
        ctl.seqClr   = 1'b1;
      end
      if (opDec[OP_ISZ]) ctl.drInc = 1'b1;
    end

    if (t6 && opDec[OP_ISZ]) begin
      ctl.memWe        = 1'b1;
      ctl.wrSrc        = WR_DR;
      ctl.pcSkipIfZero = 1'b1;
      ctl.seqClr       = 1'b1;
    end
  end

endmodule

// File: rtl/mem_ref_exec_dp.sv
module mem_ref_exec_dp
  import mem_ref_exec_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic              ldEn,
  input  logic [ADDR_W-1:0] ldAr,
  input  logic [ADDR_W-1:0] ldPc,
  input  logic [DATA_W-1:0] ldAc,
  input  logic              ldE,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] memWdata,
  output logic [DATA_W-1:0] acReg,
  output logic              eReg,
  output logic [DATA_W-1:0] drReg,
  output logic [ADDR_W-1:0] pcReg,
  output logic [ADDR_W-1:0] arReg
);

  localparam int PAD_W = DATA_W - ADDR_W;

  logic [DATA_W:0]   sumWide;
  logic              drIsZero;
  logic [DATA_W-1:0] pcWord;

  assign sumWide  = {1'b0, acReg} + {1'b0, drReg};
  assign drIsZero = (drReg == '0);

  generate
    if (PAD_W > 0) begin : gPad
      assign pcWord = {{PAD_W{1'b0}}, pcReg};
    end else begin : gNoPad
      assign pcWord = pcReg[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    case (ctl.wrSrc)
      WR_PC:   memWdata = pcWord;
      WR_DR:   memWdata = drReg;
      default: memWdata = acReg;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acReg <= '0;
      eReg  <= 1'b0;
      drReg <= '0;
      pcReg <= '0;
      arReg <= '0;
    end else if (ldEn) begin
      arReg <= ldAr;
      pcReg <= ldPc;
      acReg <= ldAc;
      eReg  <= ldE;
    end else begin
      if (ctl.drFromMem)     drReg <= memRdata;
      else if (ctl.drInc)    drReg <= drReg + 1'b1;

      if (ctl.acAnd)         acReg <= acReg & drReg;
      else if (ctl.acAdd)    {eReg, acReg} <= sumWide;
      else if (ctl.acLoadDr) acReg <= drReg;

      if (ctl.arInc)         arReg <= arReg + 1'b1;

      if (ctl.pcFromAr)      pcReg <= arReg;
      else if (ctl.pcSkipIfZero && drIsZero) pcReg <= pcReg + 1'b1;
    end
  end

endmodule

// File: rtl/mem_ref_exec.sv
module mem_ref_exec
  import mem_ref_exec_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                t4,
  input  logic                t5,
  input  logic                t6,
  input  logic [OP_COUNT-1:0] opDec,
  input  logic [DATA_W-1:0]   memRdata,
  input  logic                ldEn,
  input  logic [ADDR_W-1:0]   ldAr,
  input  logic [ADDR_W-1:0]   ldPc,
  input  logic [DATA_W-1:0]   ldAc,
  input  logic                ldE,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic                memWe,
  output logic                seqClr,
  output logic [DATA_W-1:0]   acOut,
  output logic                eOut,
  output logic [DATA_W-1:0]   drOut,
  output logic [ADDR_W-1:0]   pcOut,
  output logic [ADDR_W-1:0]   arOut
);

  ctlStrobes_t ctl;

  mem_ref_exec_ctrl uCtrl (
    .t4    (t4),
    .t5    (t5),
    .t6    (t6),
    .opDec (opDec),
    .ctl   (ctl)
  );

  mem_ref_exec_dp #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .ldEn     (ldEn),
    .ldAr     (ldAr),
    .ldPc     (ldPc),
    .ldAc     (ldAc),
    .ldE      (ldE),
    .memRdata (memRdata),
    .memWdata (memWdata),
    .acReg    (acOut),
    .eReg     (eOut),
    .drReg    (drOut),
    .pcReg    (pcOut),
    .arReg    (arOut)
  );

  assign memAddr = arOut;
  assign memWe   = ctl.memWe;
  assign seqClr  = ctl.seqClr;

  // R8
  we_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> !memWe);

  // R3
  add_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (t5 && opDec[1] && !ldEn) |=>
      ({eOut, acOut} == ({1'b0, $past(acOut)} + {1'b0, $past(drOut)})));

  // R3
  e_kept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (t5 && (opDec[0] || opDec[2]) && !ldEn) |=> $stable(eOut));

  // R6
  bsa_store_pad_chk: assert property (@(posedge clk) disable iff (!rstN)
    (t4 && opDec[5]) |-> (memWe && memWdata[DATA_W-1:ADDR_W] == '0));

  // R5
  bun_target_chk: assert property (@(posedge clk) disable iff (!rstN)
    (t4 && opDec[4] && !ldEn) |=> (pcOut == $past(arOut)));

  // R7
  isz_skip_chk: assert property (@(posedge clk) disable iff (!rstN)
    (t6 && opDec[6] && drOut == '0 && !ldEn) |=> (pcOut == $past(pcOut) + 1'b1));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!t4 && !t5 && !t6) |-> (!memWe && !seqClr));

endmodule

// File: tb/tb_mem_ref_exec.sv
module tb_mem_ref_exec;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        t4 = 0, t5 = 0, t6 = 0;
  logic [6:0]  opDec = '0;
  logic [15:0] memRdata;
  logic        ldEn = 0;
  logic [11:0] ldAr = '0, ldPc = '0;
  logic [15:0] ldAc = '0;
  logic        ldE = 0;
  logic [11:0] memAddr;
  logic [15:0] memWdata;
  logic        memWe, seqClr;
  logic [15:0] acOut, drOut;
  logic        eOut;
  logic [11:0] pcOut, arOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  logic [15:0] mem [256];

  always #10 clk = ~clk;

  assign memRdata = mem[memAddr[7:0]];
  always @(posedge clk) if (memWe) mem[memAddr[7:0]] <= memWdata;

  mem_ref_exec dut (
    .clk(clk), .rstN(rstN), .t4(t4), .t5(t5), .t6(t6), .opDec(opDec),
    .memRdata(memRdata), .ldEn(ldEn), .ldAr(ldAr), .ldPc(ldPc), .ldAc(ldAc),
    .ldE(ldE), .memAddr(memAddr), .memWdata(memWdata), .memWe(memWe),
    .seqClr(seqClr), .acOut(acOut), .eOut(eOut), .drOut(drOut),
    .pcOut(pcOut), .arOut(arOut)
  );

  // fields: op[59:57] ar[56:45] pc[44:33] ac[32:17] e[16] mem[15:0]
  localparam int NVEC = 10;
  localparam logic [59:0] VEC [NVEC] = '{
    {3'd0, 12'h010, 12'h100, 16'hF0F0, 1'b1, 16'h3C3C},
    {3'd1, 12'h011, 12'h101, 16'h7FFF, 1'b0, 16'h0001},
    {3'd1, 12'h012, 12'h102, 16'hFFFF, 1'b0, 16'h0002},
    {3'd2, 12'h013, 12'h103, 16'h1234, 1'b1, 16'hBEEF},
    {3'd3, 12'h014, 12'h104, 16'hA5A5, 1'b0, 16'h0000},
    {3'd4, 12'h0AB, 12'h105, 16'h0001, 1'b1, 16'h4444},
    {3'd5, 12'h020, 12'hFFF, 16'h0002, 1'b0, 16'h9999},
    {3'd6, 12'h030, 12'h106, 16'h0003, 1'b1, 16'h0005},
    {3'd6, 12'h031, 12'h107, 16'h0004, 1'b0, 16'hFFFF},
    {3'd5, 12'hFFF, 12'h3A7, 16'h0005, 1'b1, 16'h1111}
  };

  logic [15:0] modelDr = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int stepsFor(input int op);
    case (op)
      3, 4:    return 1;
      6:       return 3;
      default: return 2;
    endcase
  endfunction

  function automatic string reqFor(input int op);
    case (op)
      0, 2:    return "R2";
      1:       return "R3";
      3:       return "R4";
      4:       return "R5";
      5:       return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic loadRegs(input logic [11:0] a, input logic [11:0] p,
                          input logic [15:0] c, input logic ev);
    @(negedge clk);
    ldEn = 1; ldAr = a; ldPc = p; ldAc = c; ldE = ev;
    @(negedge clk);
    ldEn = 0;
  endtask

  task automatic runOp(input int op, input logic [11:0] a, input logic [11:0] p,
                       input logic [15:0] c, input logic ev, input logic [15:0] m);
    int n;
    int wrStep;
    logic [15:0] expAc, expMem, expWd;
    logic        expE;
    logic [11:0] expPc, expAr;
    logic [16:0] sum;
    string r;
    n = stepsFor(op);
    r = reqFor(op);
    mem[a[7:0]] = m;
    loadRegs(a, p, c, ev);
    expAc = c; expE = ev; expPc = p; expAr = a; expMem = m; expWd = 16'h0;
    wrStep = -1;
    case (op)
      0: begin modelDr = m; expAc = c & m; end
      1: begin modelDr = m; sum = {1'b0, c} + {1'b0, m}; expAc = sum[15:0]; expE = sum[16]; end
      2: begin modelDr = m; expAc = m; end
      3: begin expMem = c; expWd = c; wrStep = 0; end
      4: begin expPc = a; end
      5: begin expMem = {4'h0, p}; expWd = {4'h0, p}; wrStep = 0;
               expAr = a + 12'd1; expPc = a + 12'd1; end
      default: begin modelDr = m + 16'd1; expMem = m + 16'd1; expWd = m + 16'd1; wrStep = 2;
               if (modelDr == 16'h0) expPc = p + 12'd1; end
    endcase
    opDec = 7'b1 << op;
    for (int s = 0; s < n; s++) begin
      t4 = (s == 0); t5 = (s == 1); t6 = (s == 2);
      #1;
      check(seqClr == (s == n - 1), (s == n - 1) ? r : "R2", "seqClr", seqClr, (s == n - 1));
      check(memWe == (s == wrStep), "R8", "memWe", memWe, (s == wrStep));
      if (s == wrStep)
        check(memWdata == expWd, r, "memWdata", memWdata, expWd);
      @(negedge clk);
    end
    t4 = 0; t5 = 0; t6 = 0; opDec = '0;
    #1;
    check(acOut == expAc, r, "acc", acOut, expAc);
    check(eOut == expE, "R3", "ext", eOut, expE);
    check(pcOut == expPc, r, "pc", pcOut, expPc);
    check(arOut == expAr, r, "ar", arOut, expAr);
    check(drOut == modelDr, r, "dr", drOut, modelDr);
    check(mem[a[7:0]] == expMem, r, "mem", mem[a[7:0]], expMem);
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    repeat (3) @(negedge clk);
    // R1: reset state
    #1;
    check(acOut == 0 && drOut == 0 && eOut == 0 && pcOut == 0 && arOut == 0,
          "R1", "regs in reset", {acOut, drOut}, 0);
    check(!memWe && !seqClr, "R1", "strobes in reset", {memWe, seqClr}, 0);
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    #1;
    check(acOut == 0 && pcOut == 0 && arOut == 0 && eOut == 0 && drOut == 0,
          "R1", "regs after release", {acOut, pcOut}, 0);

    for (int v = 0; v < NVEC; v++) begin
      runOp(int'(VEC[v][59:57]), VEC[v][56:45], VEC[v][44:33],
            VEC[v][32:17], VEC[v][16], VEC[v][15:0]);
    end

    // R9: step strobe with no opcode, then opcode with no step strobe
    loadRegs(12'h055, 12'h066, 16'h7777, 1'b1);
    mem[8'h55] = 16'h1234;
    @(negedge clk);
    t4 = 1; opDec = '0;
    #1;
    check(!memWe && !seqClr, "R9", "strobes with no opcode", {memWe, seqClr}, 0);
    @(negedge clk);
    t4 = 0; opDec = 7'b0000010;
    #1;
    check(!memWe && !seqClr, "R9", "strobes with no step", {memWe, seqClr}, 0);
    @(negedge clk);
    opDec = '0;
    #1;
    check(acOut == 16'h7777 && eOut == 1'b1, "R9", "acc/ext held", {eOut, acOut}, {1'b1, 16'h7777});
    check(pcOut == 12'h066 && arOut == 12'h055, "R9", "pc/ar held", {pcOut, arOut}, {12'h066, 12'h055});
    check(drOut == modelDr, "R9", "dr held", drOut, modelDr);
    check(mem[8'h55] == 16'h1234, "R9", "mem untouched", mem[8'h55], 16'h1234);

    // R8: no write strobe on the read steps of a load
    runOp(2, 12'h040, 12'h200, 16'h0, 1'b0, 16'h0000);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule